// File: doc/BRIEF.md
# DMA channel enable/pause controller

This block is the per-channel control logic of a multi-channel DMA engine. Each channel owns one 32-bit configuration word. A small state machine uses that word to arm the channel, start a transfer on an external trigger, count transfer gaps, and complete the transfer. It also pauses the channel and handles a forced stop. The datapath that moves the data sits outside the block. It sees a per-channel request line, which stays high while the channel runs. For each completed beat group it returns a one-cycle transfer-gap strobe. Bus arbitration, address generation and trigger-source selection belong elsewhere.

Software reaches the words through a simple write/read port. Channel n lives at byte offset 0x10*(n+1). The enable and pause bits steer the channel. Pause and forced termination only act on a transfer gap, so a beat is never cut in half. When the last gap arrives, the controller clears enable on its own and raises a one-cycle done pulse.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset every configuration word reads 0x0000_0000, and all xfer_req, done and stopped outputs are 0.
- R2: The word for channel n (n = 0..NCH-1) is at address 0x10*(n+1). A write to any other address, including one with a nonzero low nibble, changes no channel. A read of such an address returns 0.
- R3: Writing a word with bit 31 (enable) set to an idle channel arms it. An armed channel starts (xfer_req high from the cycle after the trigger is sampled) only if glb_en is 1 in the cycle the trigger is sampled. A trigger seen while glb_en is 0 is dropped and is not held.
- R4: While a channel is armed, running or paused, bits 15:0 read back the remaining count. The count is loaded from the arming write and drops by one on each transfer-gap strobe while running.
- R5: A gap that finds the remaining count at 1 (or 0) completes the transfer. In the cycle after that gap, done is high for exactly one cycle, xfer_req is low and bit 31 reads 0. Later triggers are ignored until enable is written to 1 again.
- R6: Writing bit 31 to 0 while running does not stop the transfer at once. At the next non-final gap xfer_req falls, done stays 0, and the stopped output and bit 29 read 1.
- R7: Writing bit 30 (pause) to 1 while running halts the channel at the next non-final gap. Stopped reads 1 and the remaining count is kept. Triggers do not restart it while pause stays 1.
- R8: Setting pause on an armed channel that has not started halts it one cycle later, with stopped at 1. A trigger that arrives while paused is discarded and does not start the channel after pause is cleared.
- R9: Clearing pause on a paused channel returns it to armed one cycle later, with stopped at 0. It waits for a new trigger and then finishes the remaining count.
- R10: When the final gap arrives while a forced stop or a pause is pending, completion wins: done pulses and stopped stays 0.
- R11: Bit 29 is read-only: writes to it are ignored. Bits 28:24, 23:20 and 19:16 are stored and read back as written.
- R12: A write that changes bits 15:0 while the channel is enabled does not change the running count. When the channel is idle, bits 15:0 read back the last written value. The next arming write loads the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| glb_en | input | 1 | Global DMA enable |
| trig | input | NCH | Per-channel transfer trigger |
| gap | input | NCH | Per-channel transfer-gap strobe from the datapath |
| xfer_req | output | NCH | Per-channel run request to the datapath |
| done | output | NCH | Per-channel one-cycle completion pulse |
| stopped | output | NCH | Per-channel halted-by-pause-or-termination flag |

## Verification
The collision that matters is a transfer gap that is also the last one, in a channel that already has a forced stop or a pause waiting for that gap. The bench arms a channel with a count of 1 and starts it. It writes either enable=0 or pause=1, and then drives the single gap. It expects the done pulse, stopped low, and no termination flag. A second collision comes from a trigger in the same cycle as an armed channel that is already paused; that trigger must not start the channel, even once pause is lifted.

// File: rtl/dma_chan_ctl_pkg.sv
// Package: shared types and field layout for the DMA channel controller.
// Assumes a 32-bit configuration word; bit 31 enable, 30 pause, 29 status.
package dma_chan_ctl_pkg;

    localparam int WORD_W = 32;
    localparam int CNT_W  = 16;
    localparam int SEL_W  = 5;
    localparam int TYP_W  = 4;
    localparam int BEAT_W = 4;

    // Channel configuration word, MSB first.
    typedef struct packed {
        logic              en;
        logic              pb;
        logic              st;
        logic [SEL_W-1:0]  isel;
        logic [TYP_W-1:0]  ttype;
        logic [BEAT_W-1:0] beats;
        logic [CNT_W-1:0]  cnt;
    } cfg_word_t;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_ARMED = 2'd1,
        CH_RUN   = 2'd2,
        CH_PAUSE = 2'd3
    } ch_state_e;

endpackage

// File: rtl/dma_chan_addr_dec.sv
// Module: address decoder for the per-channel configuration words.
// Channel n answers at byte address (n+1)*STRIDE; every other address
// selects nothing. Assumes NCH*STRIDE fits in AW bits.
module dma_chan_addr_dec #(
    parameter int NCH    = 8,
    parameter int AW     = 8,
    parameter int STRIDE = 16
) (
    input  logic [AW-1:0]  addr,
    output logic [NCH-1:0] sel
);

    // One comparator per channel against its fixed offset.
    for (genvar i = 0; i < NCH; i++) begin : g_dec
        localparam logic [AW-1:0] OFS = AW'((i + 1) * STRIDE);
        assign sel[i] = (addr == OFS);
    end

endmodule

// File: rtl/dma_chan_cfg.sv
// Module: writable part of one channel's configuration word.
// Holds enable, pause, input select, type, beats and programmed count.
// The status bit is not stored here; hardware clear of enable wins
// over a software write landing on the same edge.
module dma_chan_cfg
    import dma_chan_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  cfg_word_t         wdata,
    input  logic              hw_clr_en,
    output logic              en,
    output logic              pb,
    output logic [SEL_W-1:0]  isel,
    output logic [TYP_W-1:0]  ttype,
    output logic [BEAT_W-1:0] beats,
    output logic [CNT_W-1:0]  tc_prog
);

    logic unused_st_wr;
    assign unused_st_wr = wdata.st;

    // Store software fields; completion clears enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en      <= 1'b0;
            pb      <= 1'b0;
            isel    <= '0;
            ttype   <= '0;
            beats   <= '0;
            tc_prog <= '0;
        end else begin
            if (wr) begin
                en      <= wdata.en;
                pb      <= wdata.pb;
                isel    <= wdata.isel;
                ttype   <= wdata.ttype;
                beats   <= wdata.beats;
                tc_prog <= wdata.cnt;
            end
            if (hw_clr_en) begin
                en <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dma_chan_fsm.sv
// Module: per-channel sequencing state machine.
// Arms on an enable write while idle, starts on trigger with global
// enable, counts gaps, and applies pause / forced stop only at a gap.
// Assumes en and pb are the registered configuration bits.
module dma_chan_fsm
    import dma_chan_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_wr,
    input  logic [CNT_W-1:0] tc_load,
    input  logic             en,
    input  logic             pb,
    input  logic             glb_en,
    input  logic             trig,
    input  logic             gap,
    output logic             running,
    output logic             active,
    output logic             stopped,
    output logic             done,
    output logic             clr_en,
    output logic [CNT_W-1:0] cnt
);

    ch_state_e state;
    logic      last_gap;

    // Final gap: remaining count of one, or zero programmed.
    assign last_gap = (cnt[CNT_W-1:1] == '0);
    assign running  = (state == CH_RUN);
    assign active   = (state != CH_IDLE);
    assign clr_en   = running && gap && last_gap;

    // State, remaining count, stopped flag and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= CH_IDLE;
            cnt     <= '0;
            stopped <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                CH_IDLE: begin
                    if (arm_wr) begin
                        state   <= CH_ARMED;
                        cnt     <= tc_load;
                        stopped <= 1'b0;
                    end
                end
                CH_ARMED: begin
                    if (!en) begin
                        state <= CH_IDLE;
                        cnt   <= '0;
                    end else if (pb) begin
                        state   <= CH_PAUSE;
                        stopped <= 1'b1;
                    end else if (trig && glb_en) begin
                        state <= CH_RUN;
                    end
                end
                CH_RUN: begin
                    if (gap) begin
                        if (last_gap) begin
                            state <= CH_IDLE;
                            cnt   <= '0;
                            done  <= 1'b1;
                        end else if (!en) begin
                            state   <= CH_IDLE;
                            cnt     <= '0;
                            stopped <= 1'b1;
                        end else begin
                            cnt <= cnt - 1'b1;
                            if (pb) begin
                                state   <= CH_PAUSE;
                                stopped <= 1'b1;
                            end
                        end
                    end
                end
                CH_PAUSE: begin
                    if (!en) begin
                        state <= CH_IDLE;
                        cnt   <= '0;
                    end else if (!pb) begin
                        state   <= CH_ARMED;
                        stopped <= 1'b0;
                    end
                end
                default: state <= CH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dma_chan_ctl.sv
// Module: top of the multi-channel enable/pause controller.
// One configuration word and one state machine per channel; a shared
// write/read port reaches the words at (n+1)*0x10. Reads are
// combinational. Assumes one write per cycle at most.
module dma_chan_ctl
    import dma_chan_ctl_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [AW-1:0]   reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic            glb_en,
    input  logic [NCH-1:0]  trig,
    input  logic [NCH-1:0]  gap,
    output logic [NCH-1:0]  xfer_req,
    output logic [NCH-1:0]  done,
    output logic [NCH-1:0]  stopped
);

    localparam int STRIDE = 16;

    cfg_word_t      wword;
    logic [NCH-1:0] sel;
    cfg_word_t      rd_word [NCH];

    assign wword = cfg_word_t'(reg_wdata);

    dma_chan_addr_dec #(
        .NCH    (NCH),
        .AW     (AW),
        .STRIDE (STRIDE)
    ) u_dec (
        .addr (reg_addr),
        .sel  (sel)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic              wr_i;
        logic              en_i;
        logic              pb_i;
        logic [SEL_W-1:0]  isel_i;
        logic [TYP_W-1:0]  ttype_i;
        logic [BEAT_W-1:0] beats_i;
        logic [CNT_W-1:0]  tc_prog_i;
        logic [CNT_W-1:0]  cnt_i;
        logic              active_i;
        logic              clr_en_i;

        assign wr_i = reg_wr && sel[i];

        dma_chan_cfg u_cfg (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr        (wr_i),
            .wdata     (wword),
            .hw_clr_en (clr_en_i),
            .en        (en_i),
            .pb        (pb_i),
            .isel      (isel_i),
            .ttype     (ttype_i),
            .beats     (beats_i),
            .tc_prog   (tc_prog_i)
        );

        dma_chan_fsm u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .arm_wr  (wr_i && wword.en),
            .tc_load (wword.cnt),
            .en      (en_i),
            .pb      (pb_i),
            .glb_en  (glb_en),
            .trig    (trig[i]),
            .gap     (gap[i]),
            .running (xfer_req[i]),
            .active  (active_i),
            .stopped (stopped[i]),
            .done    (done[i]),
            .clr_en  (clr_en_i),
            .cnt     (cnt_i)
        );

        // Read view: live count while active, programmed count when idle.
        always_comb begin
            rd_word[i].en    = en_i;
            rd_word[i].pb    = pb_i;
            rd_word[i].st    = stopped[i];
            rd_word[i].isel  = isel_i;
            rd_word[i].ttype = ttype_i;
            rd_word[i].beats = beats_i;
            rd_word[i].cnt   = active_i ? cnt_i : tc_prog_i;
        end
    end

    // Read mux: OR of the selected channel's word, zero when none hit.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (sel[i]) begin
                reg_rdata = reg_rdata | 32'(rd_word[i]);
            end
        end
    end

endmodule

// File: rtl/dma_chan_ctl_chk.sv
// Module: assertion checker for dma_chan_ctl, attached by bind.
// Observes only the top-level ports.
module dma_chan_ctl_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           glb_en,
    input logic [NCH-1:0] trig,
    input logic [NCH-1:0] gap,
    input logic [NCH-1:0] xfer_req,
    input logic [NCH-1:0] done,
    input logic [NCH-1:0] stopped
);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // A start needs a trigger sampled while global enable was high.
        assert_start_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(xfer_req[i]) |-> ($past(trig[i]) && $past(glb_en)));

        // Done lasts exactly one cycle.
        assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
            done[i] |=> !done[i]);

        // Done only follows a gap seen while running; request is gone.
        assert_done_from_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
            done[i] |-> ($past(xfer_req[i]) && $past(gap[i]) && !xfer_req[i]));

        // A running channel never leaves its run state without a gap.
        assert_halt_at_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (xfer_req[i] && !gap[i]) |=> xfer_req[i]);

        // A stopped channel never requests transfers.
        assert_stopped_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
            stopped[i] |-> !xfer_req[i]);

        // Completion never reports a stop.
        assert_done_not_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
            done[i] |-> !stopped[i]);
    end

endmodule

bind dma_chan_ctl dma_chan_ctl_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .glb_en   (glb_en),
    .trig     (trig),
    .gap      (gap),
    .xfer_req (xfer_req),
    .done     (done),
    .stopped  (stopped)
);

// File: tb/dma_chan_ctl_bench.sv
`timescale 1ns/1ps
module dma_chan_ctl_bench;

    localparam int NCH = 8;
    localparam int AW  = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_wr = 1'b0;
    logic [AW-1:0]  reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic           glb_en = 1'b0;
    logic [NCH-1:0] trig = '0;
    logic [NCH-1:0] gap = '0;
    logic [NCH-1:0] xfer_req;
    logic [NCH-1:0] done;
    logic [NCH-1:0] stopped;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    dma_chan_ctl #(.NCH(NCH), .AW(AW)) u_dma_chan_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .glb_en    (glb_en),
        .trig      (trig),
        .gap       (gap),
        .xfer_req  (xfer_req),
        .done      (done),
        .stopped   (stopped)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr_raw(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic wr_ch(input int ch, input logic [31:0] d);
        wr_raw(AW'((ch + 1) * 16), d);
    endtask

    task automatic rd_raw(input logic [AW-1:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic rd_ch(input int ch, output logic [31:0] v);
        rd_raw(AW'((ch + 1) * 16), v);
    endtask

    task automatic pulse_trig(input int ch);
        @(negedge clk); trig[ch] = 1'b1;
        @(negedge clk); trig[ch] = 1'b0;
    endtask

    task automatic pulse_gap(input int ch);
        @(negedge clk); gap[ch] = 1'b1;
        @(negedge clk); gap[ch] = 1'b0;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int c = 0; c < NCH; c++) begin
            rd_ch(c, v);
            check("R1 word after reset", v, 32'h0);
        end
        check("R1 outputs after reset", {8'h0, xfer_req, done, stopped}, 32'h0);
    endtask

    task automatic t_addr_fields();
        logic [31:0] v;
        wr_ch(5, 32'h0ABC_0005);
        rd_ch(5, v);
        check("R11 fields read back", v, 32'h0ABC_0005);
        wr_raw(8'h64, 32'hFFFF_FFFF);
        rd_ch(5, v);
        check("R2 unaligned write ignored", v, 32'h0ABC_0005);
        check("R2 unaligned write no start", {24'h0, xfer_req}, 32'h0);
        wr_raw(8'h00, 32'h8000_0001);
        rd_ch(0, v);
        check("R2 base address write ignored", v, 32'h0);
        rd_raw(8'h00, v);
        check("R2 read base address", v, 32'h0);
        rd_raw(8'h90, v);
        check("R2 read beyond last channel", v, 32'h0);
        wr_ch(5, 32'h2000_0000);
        rd_ch(5, v);
        check("R11 status bit not writable", v, 32'h0);
        check("R11 stopped port unchanged", {24'h0, stopped}, 32'h0);
    endtask

    task automatic t_arm_complete();
        logic [31:0] v;
        wr_ch(2, 32'h8000_0003);
        rd_ch(2, v);
        check("R3 armed word", v, 32'h8000_0003);
        glb_en = 1'b0;
        pulse_trig(2);
        check("R3 trigger without global enable", {31'h0, xfer_req[2]}, 32'h0);
        glb_en = 1'b1;
        idle_cycle();
        check("R3 dropped trigger not held", {31'h0, xfer_req[2]}, 32'h0);
        pulse_trig(2);
        check("R3 start after trigger", {31'h0, xfer_req[2]}, 32'h1);
        pulse_gap(2);
        rd_ch(2, v);
        check("R4 count after first gap", v, 32'h8000_0002);
        pulse_gap(2);
        rd_ch(2, v);
        check("R4 count after second gap", v, 32'h8000_0001);
        check("R5 no early done", {31'h0, done[2]}, 32'h0);
        pulse_gap(2);
        check("R5 done on final gap", {31'h0, done[2]}, 32'h1);
        check("R5 request drops", {31'h0, xfer_req[2]}, 32'h0);
        rd_ch(2, v);
        check("R5 enable self-cleared", v, 32'h0000_0003);
        idle_cycle();
        check("R5 done single cycle", {31'h0, done[2]}, 32'h0);
        pulse_trig(2);
        check("R5 trigger ignored after completion", {31'h0, xfer_req[2]}, 32'h0);
        // zero count completes on the first gap
        wr_ch(0, 32'h8000_0000);
        pulse_trig(0);
        pulse_gap(0);
        check("R5 zero count completes", {31'h0, done[0]}, 32'h1);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        wr_ch(3, 32'h8000_0005);
        pulse_trig(3);
        wr_ch(3, 32'h0000_0005);
        check("R6 still running before gap", {31'h0, xfer_req[3]}, 32'h1);
        pulse_gap(3);
        check("R6 stops at gap", {31'h0, xfer_req[3]}, 32'h0);
        check("R6 no done on abort", {31'h0, done[3]}, 32'h0);
        check("R6 stopped port", {31'h0, stopped[3]}, 32'h1);
        rd_ch(3, v);
        check("R6 status bit set", v, 32'h2000_0005);
        wr_ch(3, 32'h8000_0002);
        check("R6 re-arm clears stopped", {31'h0, stopped[3]}, 32'h0);
        wr_ch(3, 32'h0000_0000);
    endtask

    task automatic t_pause_run();
        logic [31:0] v;
        wr_ch(4, 32'h8000_0004);
        pulse_trig(4);
        pulse_gap(4);
        wr_ch(4, 32'hC000_0004);
        check("R7 runs until gap", {31'h0, xfer_req[4]}, 32'h1);
        pulse_gap(4);
        check("R7 halted at gap", {31'h0, xfer_req[4]}, 32'h0);
        check("R7 stopped flag", {31'h0, stopped[4]}, 32'h1);
        rd_ch(4, v);
        check("R7 count kept", v, 32'hE000_0002);
        pulse_trig(4);
        check("R7 no resume while paused", {31'h0, xfer_req[4]}, 32'h0);
        wr_ch(4, 32'h8000_0004);
        idle_cycle();
        check("R9 unpause clears stopped", {31'h0, stopped[4]}, 32'h0);
        check("R9 waits for new trigger", {31'h0, xfer_req[4]}, 32'h0);
        rd_ch(4, v);
        check("R9 remaining count after unpause", v, 32'h8000_0002);
        pulse_trig(4);
        check("R9 restarts on trigger", {31'h0, xfer_req[4]}, 32'h1);
        pulse_gap(4);
        check("R9 not done one early", {31'h0, done[4]}, 32'h0);
        pulse_gap(4);
        check("R9 completes remaining", {31'h0, done[4]}, 32'h1);
    endtask

    task automatic t_pause_armed();
        wr_ch(1, 32'h8000_0002);
        wr_ch(1, 32'hC000_0002);
        idle_cycle();
        check("R8 immediate pause", {31'h0, stopped[1]}, 32'h1);
        pulse_trig(1);
        check("R8 trigger while paused", {31'h0, xfer_req[1]}, 32'h0);
        wr_ch(1, 32'h8000_0002);
        idle_cycle();
        check("R8 discarded trigger not replayed", {31'h0, xfer_req[1]}, 32'h0);
        check("R8 stopped cleared", {31'h0, stopped[1]}, 32'h0);
        pulse_trig(1);
        check("R8 starts on fresh trigger", {31'h0, xfer_req[1]}, 32'h1);
        pulse_gap(1);
        pulse_gap(1);
        check("R8 completes after pause", {31'h0, done[1]}, 32'h1);
    endtask

    task automatic t_final_race();
        logic [31:0] v;
        wr_ch(6, 32'h8000_0001);
        pulse_trig(6);
        wr_ch(6, 32'h0000_0001);
        pulse_gap(6);
        check("R10 final gap beats abort: done", {31'h0, done[6]}, 32'h1);
        check("R10 final gap beats abort: stopped", {31'h0, stopped[6]}, 32'h0);
        wr_ch(6, 32'h8000_0001);
        pulse_trig(6);
        wr_ch(6, 32'hC000_0001);
        pulse_gap(6);
        check("R10 final gap beats pause: done", {31'h0, done[6]}, 32'h1);
        check("R10 final gap beats pause: stopped", {31'h0, stopped[6]}, 32'h0);
        rd_ch(6, v);
        check("R10 word after race", v, 32'h4000_0001);
        wr_ch(6, 32'h0000_0000);
    endtask

    task automatic t_tc_shadow();
        logic [31:0] v;
        wr_ch(7, 32'h8000_0002);
        pulse_trig(7);
        wr_ch(7, 32'h8000_0005);
        rd_ch(7, v);
        check("R12 running count unchanged", v, 32'h8000_0002);
        pulse_gap(7);
        check("R12 not done after one gap", {31'h0, done[7]}, 32'h0);
        pulse_gap(7);
        check("R12 done on old count", {31'h0, done[7]}, 32'h1);
        rd_ch(7, v);
        check("R12 new count stored", v, 32'h0000_0005);
        wr_ch(7, 32'h8000_0005);
        pulse_trig(7);
        for (int k = 0; k < 4; k++) begin
            pulse_gap(7);
            check("R12 new count not yet done", {31'h0, done[7]}, 32'h0);
        end
        pulse_gap(7);
        check("R12 new count done", {31'h0, done[7]}, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle_cycle();
        t_reset();
        t_addr_fields();
        t_arm_complete();
        t_abort();
        t_pause_run();
        t_pause_armed();
        t_final_race();
        t_tc_shadow();
        idle_cycle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule